// File: doc/BRIEF.md
# Single-Precision Float to Integer Truncating Converter

This block turns a 32-bit single-precision floating-point word into a 32-bit two's-complement integer. The fractional part is dropped, so the result always moves toward zero. The operand is sorted by its exponent field into one of these groups:

- zero or subnormal;
- magnitude below one;
- in-range normal;
- too large;
- infinity;
- not-a-number.

Each group has a fixed result, so no input pattern leaves the output undefined.

An operand is presented with a one-cycle strobe on `in_vld`. The result and an `bad_op` flag come out of a register one clock later, marked by `out_vld`. The block takes a new operand on every cycle and has no back-pressure: there is no ready signal, and the downstream logic must accept each result in the cycle that `out_vld` is high. Between strobes the output register keeps the last result.

Top module: `f2i_trunc`

## Requirements
- R1: `out_vld` is high exactly one clock after each cycle in which `in_vld` was high. A synchronous reset clears `out_vld`, `bad_op` and `res_int`. A new operand can be accepted on every cycle.
- R2: For a positive normal operand with unbiased exponent E from 0 to 30, `res_int` is the integer part of 1.fraction × 2^E, and `bad_op` is low.
- R3: For a negative operand in the same range, `res_int` is the bitwise inverse of the truncated magnitude plus one, which is rounding toward zero. For example, -2.5 gives -2 and `bad_op` is low.
- R4: An exponent field of 0 gives `res_int` = 0 and `bad_op` low, for any sign and fraction. This covers +0, -0 and subnormals.
- R5: A normal operand with exponent field below 127 (magnitude under one) gives 0 with `bad_op` low, for both signs.
- R6: An exponent field of 255 with a zero fraction (infinity) gives 0x7FFFFFFF when bit 31 is 0 and 0x80000000 when bit 31 is 1. In both cases `bad_op` is high.
- R7: An exponent field of 255 with a nonzero fraction (NaN) gives 0x80000000 with `bad_op` high, for either sign.
- R8: A finite operand with exponent field 158 or more (E ≥ 31) saturates to 0x7FFFFFFF when positive and 0x80000000 when negative, with `bad_op` high.
- R9: The operand 0xCF000000 (exactly -2^31) gives 0x80000000 with `bad_op` low.
- R10: When `in_vld` is low, `res_int` keeps its value. `bad_op` is low whenever `out_vld` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Operand strobe |
| in_word | input | 32 | Floating-point operand: sign bit 31, exponent field bits 30:23, fraction bits 22:0 |
| out_vld | output | 1 | Result strobe, one cycle after `in_vld` |
| res_int | output | 32 | Truncated two's-complement result |
| bad_op | output | 1 | High for NaN, infinity and out-of-range operands |

## Verification
The hardest cases to reach from the ports are the narrow edges of the exponent range. These are the single exact value -2^31, the largest in-range values just under 2^31, and the step from exponent field 157 to 158. A uniformly random word almost never lands on them.

The stimulus therefore names these words directly. It also draws most random exponents from a window around the bias and the saturation limit, so truncation and saturation are both exercised heavily.

A back-to-back burst checks that results come out at the full rate of one per cycle.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  typedef enum logic [2:0] {
    CL_ZERO = 3'd0,
    CL_NORM = 3'd1,
    CL_OVER = 3'd2,
    CL_MINX = 3'd3,
    CL_INF  = 3'd4,
    CL_NAN  = 3'd5
  } f2i_class_e;
endpackage

// File: rtl/f2i_classify.sv
module f2i_classify
  import f2i_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32
) (
  input  logic              sgn,
  input  logic [EXP_W-1:0]  exp_f,
  input  logic [FRAC_W-1:0] frac_f,
  output f2i_class_e        cls
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] EXP_ONE = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] EXP_LIM = EXP_W'(BIAS + INT_W - 1);
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

  logic frac_zero;
  assign frac_zero = (frac_f == '0);

  always_comb begin
    if (exp_f == EXP_MAX)
      cls = frac_zero ? CL_INF : CL_NAN;
    else if (exp_f < EXP_ONE)
      cls = CL_ZERO;
    else if (exp_f == EXP_LIM && sgn && frac_zero)
      cls = CL_MINX;
    else if (exp_f >= EXP_LIM)
      cls = CL_OVER;
    else
      cls = CL_NORM;
  end
endmodule

// File: rtl/f2i_shift.sv
module f2i_shift #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32
) (
  input  logic [EXP_W-1:0]  exp_f,
  input  logic [FRAC_W-1:0] frac_f,
  output logic [INT_W-1:0]  mag
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int SIG_W = FRAC_W + 1;
  localparam logic [EXP_W-1:0] BIAS_E = EXP_W'(BIAS);
  localparam logic [EXP_W-1:0] FRAC_E = EXP_W'(FRAC_W);

  logic [SIG_W-1:0] sig;
  logic [INT_W-1:0] wide;
  logic [EXP_W-1:0] e_unb;

  assign sig   = {1'b1, frac_f};
  assign e_unb = exp_f - BIAS_E;

  generate
    if (INT_W >= SIG_W) begin : g_ext
      assign wide = INT_W'(sig);
    end else begin : g_cut
      assign wide = sig[SIG_W-1 -: INT_W];
    end
  endgenerate

  always_comb begin
    if (e_unb >= FRAC_E)
      mag = wide << (e_unb - FRAC_E);
    else
      mag = wide >> (FRAC_E - e_unb);
  end
endmodule

// File: rtl/f2i_apply.sv
module f2i_apply
  import f2i_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  f2i_class_e       cls,
  input  logic             sgn,
  input  logic [INT_W-1:0] mag,
  output logic [INT_W-1:0] res,
  output logic             bad
);
  localparam logic [INT_W-1:0] INT_MIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] INT_MAX = {1'b0, {(INT_W-1){1'b1}}};

  logic [INT_W-1:0] neg_mag;
  assign neg_mag = ~mag + INT_W'(1);

  always_comb begin
    res = '0;
    bad = 1'b0;
    unique case (cls)
      CL_ZERO: res = '0;
      CL_NORM: res = sgn ? neg_mag : mag;
      CL_MINX: res = INT_MIN;
      CL_OVER, CL_INF: begin
        res = sgn ? INT_MIN : INT_MAX;
        bad = 1'b1;
      end
      CL_NAN: begin
        res = INT_MIN;
        bad = 1'b1;
      end
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/f2i_trunc.sv
module f2i_trunc
  import f2i_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_vld,
  input  logic [EXP_W+FRAC_W:0]     in_word,
  output logic                      out_vld,
  output logic [INT_W-1:0]          res_int,
  output logic                      bad_op
);
  localparam int WORD_W = EXP_W + FRAC_W + 1;

  logic              sgn;
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  f2i_class_e        cls;
  logic [INT_W-1:0]  mag;
  logic [INT_W-1:0]  res_d;
  logic              bad_d;

  assign sgn    = in_word[WORD_W-1];
  assign exp_f  = in_word[WORD_W-2 -: EXP_W];
  assign frac_f = in_word[FRAC_W-1:0];

  f2i_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_cls (
    .sgn(sgn), .exp_f(exp_f), .frac_f(frac_f), .cls(cls)
  );

  f2i_shift #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_shf (
    .exp_f(exp_f), .frac_f(frac_f), .mag(mag)
  );

  f2i_apply #(.INT_W(INT_W)) u_app (
    .cls(cls), .sgn(sgn), .mag(mag), .res(res_d), .bad(bad_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      bad_op  <= 1'b0;
      res_int <= '0;
    end else begin
      out_vld <= in_vld;
      bad_op  <= in_vld & bad_d;
      if (in_vld) res_int <= res_d;
    end
  end
endmodule

// File: rtl/f2i_trunc_chk.sv
module f2i_trunc_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  parameter int INT_W  = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_vld,
  input logic [EXP_W+FRAC_W:0] in_word,
  input logic                  out_vld,
  input logic [INT_W-1:0]      res_int,
  input logic                  bad_op
);
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int WORD_W = EXP_W + FRAC_W + 1;
  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};
  localparam logic [EXP_W-1:0] EXP_ONE = EXP_W'(BIAS);
  localparam logic [INT_W-1:0] INT_MIN = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] MIN_WORD = {1'b1, EXP_W'(BIAS + INT_W - 1), {FRAC_W{1'b0}}};

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  assign exp_f  = in_word[WORD_W-2 -: EXP_W];
  assign frac_f = in_word[FRAC_W-1:0];

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_vld == $past(in_vld)));

  assert_small_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (in_vld && exp_f < EXP_ONE) |=> (res_int == '0 && !bad_op));

  assert_nan_R7: assert property (@(posedge clk) disable iff (rst)
    (in_vld && exp_f == EXP_MAX && frac_f != '0) |=> (res_int == INT_MIN && bad_op));

  assert_exact_min_R9: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_word == MIN_WORD) |=> (res_int == INT_MIN && !bad_op));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!in_vld && !$past(rst)) |=> $stable(res_int));

  assert_flag_gated_R10: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> !bad_op);
endmodule

bind f2i_trunc f2i_trunc_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .INT_W(INT_W)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .in_word(in_word),
  .out_vld(out_vld), .res_int(res_int), .bad_op(bad_op)
);

// File: tb/tb_f2i_trunc.sv
`timescale 1ns/1ps
module tb_f2i_trunc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [31:0] in_word = '0;
  logic        out_vld;
  logic [31:0] res_int;
  logic        bad_op;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  f2i_trunc dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_word(in_word),
    .out_vld(out_vld), .res_int(res_int), .bad_op(bad_op)
  );

  function automatic void model(input logic [31:0] w, output logic [31:0] r,
                                output logic b, output string tag);
    logic s; int e; int f; real m; real v;
    s = w[31]; e = int'(w[30:23]); f = int'(w[22:0]);
    if (e == 255) begin
      b = 1'b1;
      if (f != 0) begin r = 32'h8000_0000; tag = "R7"; end
      else begin r = s ? 32'h8000_0000 : 32'h7FFF_FFFF; tag = "R6"; end
      return;
    end
    if (e == 0) begin m = real'(f) / 8388608.0; e = -126; end
    else begin m = 1.0 + real'(f) / 8388608.0; e = e - 127; end
    v = m * (2.0 ** e);
    if (s) v = -v;
    b = 1'b0;
    if (v >= 2147483648.0) begin r = 32'h7FFF_FFFF; b = 1'b1; tag = "R8"; end
    else if (v < -2147483648.0) begin r = 32'h8000_0000; b = 1'b1; tag = "R8"; end
    else begin
      r = 32'($rtoi(v));
      if (w[30:23] == 8'd0) tag = "R4";
      else if (w[30:23] < 8'd127) tag = "R5";
      else if (v == -2147483648.0) tag = "R9";
      else tag = s ? "R3" : "R2";
    end
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_one(input logic [31:0] w);
    logic [31:0] er; logic eb; string tg;
    model(w, er, eb, tg);
    @(negedge clk);
    in_vld = 1'b1; in_word = w;
    @(negedge clk);
    in_vld = 1'b0;
    check(out_vld === 1'b1, "R1", "out_vld", 32'(out_vld), 32'd1);
    check(res_int === er, tg, $sformatf("result for %h", w), res_int, er);
    check(bad_op === eb, tg, $sformatf("bad_op for %h", w), 32'(bad_op), 32'(eb));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] keep, er, w;
    logic eb;
    string tg;
    void'($urandom(32'd7741));
    in_vld = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0; in_vld = 1'b0;
    check(out_vld === 1'b0 && bad_op === 1'b0 && res_int === 32'd0, "R1",
          "reset state", res_int, 32'd0);

    run_one(32'h0000_0000); run_one(32'h8000_0000);
    run_one(32'h0000_0001); run_one(32'h807F_FFFF);
    run_one(32'h3F7F_FFFF); run_one(32'hBF7F_FFFF);
    run_one(32'h3F80_0000); run_one(32'hBF80_0000);
    run_one(32'h4020_0000); run_one(32'hC020_0000);
    run_one(32'h4B7F_FFFF); run_one(32'h4EFF_FFFF);
    run_one(32'hCEFF_FFFF); run_one(32'h4F00_0000);
    run_one(32'hCF00_0000); run_one(32'hCF00_0001);
    run_one(32'h7F7F_FFFF); run_one(32'h7F80_0000);
    run_one(32'hFF80_0000); run_one(32'h7FC0_0000);
    run_one(32'hFF80_0001);

    // R10: result holds while in_vld is low even though in_word changes
    keep = res_int;
    in_word = 32'h4100_0000;
    @(negedge clk);
    check(res_int === keep, "R10", "hold result", res_int, keep);
    check(out_vld === 1'b0 && bad_op === 1'b0, "R10", "flags idle",
          {30'd0, out_vld, bad_op}, 32'd0);

    for (int i = 0; i < 3000; i++) begin
      w = $urandom;
      if (($urandom % 4) != 0) w[30:23] = 8'(100 + ($urandom % 62));
      run_one(w);
    end

    // R1: back-to-back stream, one result per cycle
    begin
      logic [31:0] prev_r; logic prev_b;
      for (int i = 0; i < 200; i++) begin
        w = $urandom;
        w[30:23] = 8'(120 + ($urandom % 40));
        @(negedge clk);
        if (i > 0) begin
          check(out_vld === 1'b1, "R1", "stream valid", 32'(out_vld), 32'd1);
          check(res_int === prev_r && bad_op === prev_b, "R1", "stream result",
                res_int, prev_r);
        end
        in_vld = 1'b1; in_word = w;
        model(w, er, eb, tg);
        prev_r = er; prev_b = eb;
      end
      @(negedge clk);
      in_vld = 1'b0;
      check(res_int === prev_r && bad_op === prev_b, "R1", "stream last", res_int, prev_r);
    end

    // R1: reset clears outputs
    @(negedge clk);
    in_vld = 1'b1; in_word = 32'h7FC0_0000; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; in_vld = 1'b0;
    check(out_vld === 1'b0 && bad_op === 1'b0 && res_int === 32'd0, "R1",
          "reset clears", res_int, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule